// File: doc/BRIEF.md
# Store Queue with Read-Miss Bypass

This block sits between a data cache and the next memory level. Stores enter a small first-in first-out queue, so the processor does not wait for memory on a write as long as a slot is free. Queued stores leave for memory one at a time, oldest first, over a shared request port with a ready/valid handshake.

Read misses do not wait behind queued stores. Each read-miss address is compared with every occupied slot. When no slot matches, the read takes the memory port at once, ahead of any queued store. When one or more slots match, the block answers the read itself from the most recently queued matching store and memory sees no read. A conservative mode can be selected instead. In that mode a read miss is held until the queue has emptied and then always goes to memory.

A single read is in flight at a time. Memory returns read data on a response strobe, and the block presents every read result, forwarded or fetched, one cycle after it is known.

Top module: `wbuf_bypass`

## Requirements
- R1: `wr_ready` is high while fewer than 4 stores are queued. With 4 queued it is low, and a store offered then is dropped and never reaches memory.
- R2: Queued stores are offered on the memory port with `mem_req_write`=1, carrying their address and data. They are removed one per accepted handshake, in the order they were accepted.
- R3: In normal mode (`strict_mode`=0), a read whose address matches no queued store is driven on the memory port in the same cycle it is presented, with `mem_req_write`=0 and its address, even while stores are queued. `rd_ready` then equals `mem_req_ready`.
- R4: In normal mode, a read whose address matches a queued store is accepted in the cycle it is presented (`rd_ready`=1) and puts no read on the memory port. The next cycle has `rsp_valid`=1 and `rsp_fwd`=1.
- R5: When several queued stores match a read, the returned data is that of the most recently accepted one.
- R6: A memory read response (`mem_rsp_valid`) is presented in the following cycle on `rsp_valid` and `rsp_data`, with `rsp_fwd`=0.
- R7: When a read and a queued store both want the memory port in the same cycle, the read is offered. The store stays queued.
- R8: With `strict_mode`=1, `rd_ready` stays low and no read is offered while any store is queued. Once the queue is empty the read goes to memory, and no data is forwarded.
- R9: After a read has been handed to memory, `rd_ready` stays low until that read's response has arrived.
- R10: After reset the queue is empty: `wr_ready`=1, `rsp_valid`=0 and `mem_req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strict_mode | input | 1 | 1: reads wait for the queue to empty |
| wr_valid | input | 1 | Store offered |
| wr_ready | output | 1 | Queue has a free slot |
| wr_addr | input | 32 | Store address |
| wr_data | input | 32 | Store data |
| rd_valid | input | 1 | Read miss offered |
| rd_ready | output | 1 | Read miss accepted |
| rd_addr | input | 32 | Read-miss address |
| rsp_valid | output | 1 | Read result valid |
| rsp_data | output | 32 | Read result data |
| rsp_fwd | output | 1 | 1: result came from a queued store |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1: store drain, 0: read |
| mem_req_addr | output | 32 | Memory request address |
| mem_req_data | output | 32 | Memory store data |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |

## Verification
The hardest case to reach from the ports is a read that meets a busy, non-empty queue. A store drain must be pending on the memory port in the same cycle, and for R5 the queue must hold two stores to the same address. The stimulus gets there by holding `mem_req_ready` low so stores pile up without draining. It then presents the read, and raises `mem_req_ready` only in the cycle where the read and a drain are both asking for the port. The bench then counts the stores that memory logs to show that none left with the read. The conservative mode is driven with a read that matches a queued store. Its response must carry the memory value rather than the queued one.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    // State of the single outstanding read miss
    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_WAIT = 1'b1
    } rd_state_e;

endpackage

// File: rtl/wbuf_store.sv
// Circular store queue: slots addressed by pointer, occupancy by count.
module wbuf_store #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [AW-1:0]             push_addr,
    input  logic [DW-1:0]             push_data,
    input  logic                      pop,
    output logic [DEPTH-1:0][AW-1:0]  slot_addr,
    output logic [DEPTH-1:0][DW-1:0]  slot_data,
    output logic [DEPTH-1:0]          slot_live,
    output logic [$clog2(DEPTH)-1:0]  head_ptr,
    output logic [AW-1:0]             head_addr,
    output logic [DW-1:0]             head_data,
    output logic                      empty,
    output logic                      full
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW:0] CNT_FULL = (PW+1)'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [PW-1:0]            head;
        logic [PW-1:0]            tail;
        logic [PW:0]              count;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.addr[st_q.tail] = push_addr;
            st_d.data[st_q.tail] = push_data;
            st_d.tail            = st_q.tail + 1'b1;
        end
        if (pop) begin
            st_d.head = st_q.head + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // A slot is live when its age behind the head is below the count
    for (genvar i = 0; i < DEPTH; i++) begin : g_live
        logic [PW-1:0] age;
        assign age          = PW'(i) - st_q.head;
        assign slot_live[i] = ({1'b0, age} < st_q.count);
    end

    assign slot_addr = st_q.addr;
    assign slot_data = st_q.data;
    assign head_ptr  = st_q.head;
    assign head_addr = st_q.addr[st_q.head];
    assign head_data = st_q.data[st_q.head];
    assign empty     = (st_q.count == '0);
    assign full      = (st_q.count == CNT_FULL);

endmodule

// File: rtl/wbuf_match.sv
// Associative lookup of a read address; the youngest matching slot wins.
module wbuf_match #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic [DEPTH-1:0][AW-1:0]  slot_addr,
    input  logic [DEPTH-1:0][DW-1:0]  slot_data,
    input  logic [DEPTH-1:0]          slot_live,
    input  logic [$clog2(DEPTH)-1:0]  head_ptr,
    input  logic [AW-1:0]             look_addr,
    output logic                      hit,
    output logic [DW-1:0]             hit_data
);
    localparam int PW = $clog2(DEPTH);

    logic [DEPTH-1:0] eq_vec;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign eq_vec[i] = slot_live[i] && (slot_addr[i] == look_addr);
    end

    // Walk from oldest to youngest; a later match overrides an earlier one
    always_comb begin
        logic [PW-1:0] idx;
        hit      = 1'b0;
        hit_data = '0;
        idx      = '0;
        for (int age = 0; age < DEPTH; age++) begin
            idx = head_ptr + PW'(age);
            if (eq_vec[idx]) begin
                hit      = 1'b1;
                hit_data = slot_data[idx];
            end
        end
    end

endmodule

// File: rtl/wbuf_ctrl.sv
// Read-miss sequencing and memory-port arbitration (reads before drains).
module wbuf_ctrl
    import wbuf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strict_mode,
    input  logic          rd_valid,
    output logic          rd_ready,
    input  logic          q_empty,
    input  logic          fwd_hit,
    input  logic [DW-1:0] fwd_data,
    output logic          port_valid,
    output logic          port_is_read,
    input  logic          port_ready,
    output logic          drain_pop,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_fwd
);
    typedef struct packed {
        rd_state_e     state;
        logic          rsp_valid;
        logic          rsp_fwd;
        logic [DW-1:0] rsp_data;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic look_ok;
    logic take_fwd;
    logic take_mem;

    always_comb begin
        look_ok  = (st_q.state == RD_IDLE) && rd_valid && (!strict_mode || q_empty);
        take_fwd = look_ok && fwd_hit && !strict_mode;
        take_mem = look_ok && !take_fwd;

        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_fwd   = 1'b0;

        case (st_q.state)
            RD_IDLE: begin
                if (take_fwd) begin
                    st_d.rsp_valid = 1'b1;
                    st_d.rsp_fwd   = 1'b1;
                    st_d.rsp_data  = fwd_data;
                end else if (take_mem && port_ready) begin
                    st_d.state = RD_WAIT;
                end
            end
            RD_WAIT: begin
                if (mem_rsp_valid) begin
                    st_d.state     = RD_IDLE;
                    st_d.rsp_valid = 1'b1;
                    st_d.rsp_data  = mem_rsp_data;
                end
            end
            default: st_d.state = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{state: RD_IDLE, rsp_valid: 1'b0, rsp_fwd: 1'b0, rsp_data: '0};
        else        st_q <= st_d;
    end

    assign port_is_read = take_mem;
    assign port_valid   = take_mem || !q_empty;
    assign drain_pop    = !take_mem && !q_empty && port_ready;
    assign rd_ready     = take_fwd || (take_mem && port_ready);
    assign rsp_valid    = st_q.rsp_valid;
    assign rsp_data     = st_q.rsp_data;
    assign rsp_fwd      = st_q.rsp_fwd;

endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strict_mode,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_valid,
    output logic          rd_ready,
    input  logic [AW-1:0] rd_addr,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_fwd,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_data,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data
);
    localparam int PW = $clog2(DEPTH);

    logic [DEPTH-1:0][AW-1:0] slot_addr;
    logic [DEPTH-1:0][DW-1:0] slot_data;
    logic [DEPTH-1:0]         slot_live;
    logic [PW-1:0]            head_ptr;
    logic [AW-1:0]            head_addr;
    logic [DW-1:0]            head_data;
    logic                     buf_empty;
    logic                     buf_full;
    logic                     drain_pop;
    logic                     push;
    logic                     fwd_hit;
    logic [DW-1:0]            fwd_data;
    logic                     port_is_read;

    assign push     = wr_valid && !buf_full;
    assign wr_ready = !buf_full;

    wbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (wr_addr),
        .push_data (wr_data),
        .pop       (drain_pop),
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .slot_live (slot_live),
        .head_ptr  (head_ptr),
        .head_addr (head_addr),
        .head_data (head_data),
        .empty     (buf_empty),
        .full      (buf_full)
    );

    wbuf_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_match (
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .slot_live (slot_live),
        .head_ptr  (head_ptr),
        .look_addr (rd_addr),
        .hit       (fwd_hit),
        .hit_data  (fwd_data)
    );

    wbuf_ctrl #(.DW(DW)) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .strict_mode   (strict_mode),
        .rd_valid      (rd_valid),
        .rd_ready      (rd_ready),
        .q_empty       (buf_empty),
        .fwd_hit       (fwd_hit),
        .fwd_data      (fwd_data),
        .port_valid    (mem_req_valid),
        .port_is_read  (port_is_read),
        .port_ready    (mem_req_ready),
        .drain_pop     (drain_pop),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_data      (rsp_data),
        .rsp_fwd       (rsp_fwd)
    );

    assign mem_req_write = !port_is_read;
    assign mem_req_addr  = port_is_read ? rd_addr : head_addr;
    assign mem_req_data  = head_data;

endmodule

// File: rtl/wbuf_bypass_chk.sv
module wbuf_bypass_chk (
    input logic clk,
    input logic rst_n,
    input logic strict_mode,
    input logic wr_ready,
    input logic rd_valid,
    input logic rd_ready,
    input logic buf_empty,
    input logic buf_full,
    input logic drain_pop,
    input logic mem_req_valid,
    input logic mem_req_ready,
    input logic mem_req_write,
    input logic mem_rsp_valid,
    input logic rsp_valid,
    input logic rsp_fwd
);
    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !drain_pop) |=> buf_full);

    // R1
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> !wr_ready);

    // R2
    drain_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drain_pop |-> (mem_req_valid && mem_req_ready && mem_req_write));

    // R7
    read_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write) |-> !drain_pop);

    // R4
    fwd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && !(mem_req_valid && !mem_req_write)) |=> (rsp_valid && rsp_fwd));

    // R6
    mem_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |=> (rsp_valid && !rsp_fwd));

    // R8
    strict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strict_mode && !buf_empty) |-> !rd_ready);

    // R9
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && !mem_req_write) |=> !rd_ready);

endmodule

bind wbuf_bypass wbuf_bypass_chk i_wbuf_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .strict_mode   (strict_mode),
    .wr_ready      (wr_ready),
    .rd_valid      (rd_valid),
    .rd_ready      (rd_ready),
    .buf_empty     (buf_empty),
    .buf_full      (buf_full),
    .drain_pop     (drain_pop),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_valid     (rsp_valid),
    .rsp_fwd       (rsp_fwd)
);

// File: tb/test_wbuf_bypass.sv
module test_wbuf_bypass;
    localparam logic [31:0] MEM_KEY = 32'h5A00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strict_mode = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [31:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_valid = 1'b0;
    logic        rd_ready;
    logic [31:0] rd_addr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_fwd;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_data;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Memory model: logs drained stores, answers reads two edges later
    logic [31:0] wlog_a [32];
    logic [31:0] wlog_d [32];
    int          wn = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;

    always #4 clk = ~clk;

    wbuf_bypass i_wbuf_bypass (
        .clk(clk), .rst_n(rst_n), .strict_mode(strict_mode),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fwd(rsp_fwd),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_data(mem_req_data), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            pend          <= 1'b0;
            mem_rsp_valid <= 1'b0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (pend) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= MEM_KEY ^ pend_addr;
                pend          <= 1'b0;
            end
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    wlog_a[wn] <= mem_req_addr;
                    wlog_d[wn] <= mem_req_data;
                    wn         <= wn + 1;
                end else begin
                    pend      <= 1'b1;
                    pend_addr <= mem_req_addr;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_store(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        #1 chk(wr_ready == 1'b1, "R1 wr_ready with room", 32'(wr_ready), 32'd1);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(wr_ready == 1'b1, "R10 wr_ready after reset", 32'(wr_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk(mem_req_valid == 1'b0, "R10 mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
    endtask

    task automatic t_fill();
        int base;
        mem_req_ready = 1'b0;
        base = wn;
        for (int i = 0; i < 4; i++) push_store(32'h1000 + 32'(i*4), 32'hD0 + 32'(i));
        chk(wr_ready == 1'b0, "R1 wr_ready when full", 32'(wr_ready), 32'd0);
        wr_valid = 1'b1; wr_addr = 32'hBAD0; wr_data = 32'hBAD;
        @(negedge clk);
        wr_valid = 1'b0;
        mem_req_ready = 1'b1;
        repeat (8) @(negedge clk);
        chk(wn == base + 4, "R1 dropped store not drained", 32'(wn - base), 32'd4);
        for (int i = 0; i < 4; i++) begin
            chk(wlog_a[base+i] == 32'h1000 + 32'(i*4), "R2 drain order address", wlog_a[base+i], 32'h1000 + 32'(i*4));
            chk(wlog_d[base+i] == 32'hD0 + 32'(i), "R2 drain order data", wlog_d[base+i], 32'hD0 + 32'(i));
        end
        chk(wr_ready == 1'b1, "R1 wr_ready after drain", 32'(wr_ready), 32'd1);
    endtask

    task automatic t_fwd();
        mem_req_ready = 1'b0;
        push_store(32'h100, 32'h1);
        push_store(32'h200, 32'h2);
        push_store(32'h100, 32'h3);
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = 32'h100;
        #1;
        chk(rd_ready == 1'b1, "R4 forward accepted at once", 32'(rd_ready), 32'd1);
        chk(mem_req_write == 1'b1, "R4 no memory read on hit", 32'(mem_req_write), 32'd1);
        @(negedge clk);
        chk(rsp_valid && rsp_fwd, "R4 forwarded response flags", {30'd0, rsp_valid, rsp_fwd}, 32'd3);
        chk(rsp_data == 32'h3, "R5 youngest match supplies data", rsp_data, 32'h3);
        rd_addr = 32'h200;
        #1 chk(rd_ready == 1'b1, "R4 second forward accepted", 32'(rd_ready), 32'd1);
        @(negedge clk);
        rd_valid = 1'b0;
        chk(rsp_valid && rsp_fwd && rsp_data == 32'h2, "R4 forwarded data", rsp_data, 32'h2);
    endtask

    task automatic t_bypass();
        int base;
        base = wn;
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = 32'h300;
        #1;
        chk(mem_req_valid && !mem_req_write, "R3 miss read offered past queue", 32'(mem_req_write), 32'd0);
        chk(mem_req_addr == 32'h300, "R3 read address", mem_req_addr, 32'h300);
        chk(rd_ready == 1'b0, "R3 rd_ready follows mem_req_ready low", 32'(rd_ready), 32'd0);
        @(negedge clk);
        mem_req_ready = 1'b1;
        #1;
        chk(rd_ready == 1'b1 && mem_req_write == 1'b0, "R7 read wins the port", 32'(mem_req_write), 32'd0);
        @(negedge clk);
        chk(wn == base, "R7 no store drained with read", 32'(wn - base), 32'd0);
        chk(rsp_valid == 1'b0, "R6 no response yet", 32'(rsp_valid), 32'd0);
        rd_addr = 32'h400;
        #1 chk(rd_ready == 1'b0, "R9 second read held", 32'(rd_ready), 32'd0);
        @(negedge clk);
        rd_valid = 1'b0;
        chk(rsp_valid == 1'b0, "R6 response not early", 32'(rsp_valid), 32'd0);
        @(negedge clk);
        chk(rsp_valid && !rsp_fwd, "R6 memory response flags", {30'd0, rsp_valid, rsp_fwd}, 32'd2);
        chk(rsp_data == (MEM_KEY ^ 32'h300), "R6 memory response data", rsp_data, MEM_KEY ^ 32'h300);
        repeat (4) @(negedge clk);
        chk(wn == base + 3, "R2 queued stores drained after read", 32'(wn - base), 32'd3);
        chk(wlog_a[base] == 32'h100 && wlog_a[base+1] == 32'h200 && wlog_d[base+2] == 32'h3,
            "R2 order after bypass", wlog_d[base+2], 32'h3);
    endtask

    task automatic t_strict();
        int base;
        bit seen;
        mem_req_ready = 1'b0;
        push_store(32'h500, 32'h55);
        push_store(32'h600, 32'h66);
        base = wn;
        @(negedge clk);
        strict_mode = 1'b1; rd_valid = 1'b1; rd_addr = 32'h500;
        #1;
        chk(rd_ready == 1'b0, "R8 read held while queue busy", 32'(rd_ready), 32'd0);
        chk(mem_req_write == 1'b1, "R8 no read offered while busy", 32'(mem_req_write), 32'd1);
        mem_req_ready = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 10 && !seen; i++) begin
            @(negedge clk);
            #1;
            if (rd_ready) seen = 1'b1;
        end
        chk(seen, "R8 read released after drain", 32'(seen), 32'd1);
        chk(wn == base + 2, "R8 queue empty before read", 32'(wn - base), 32'd2);
        chk(mem_req_write == 1'b0 && mem_req_addr == 32'h500, "R8 read goes to memory", mem_req_addr, 32'h500);
        @(negedge clk);
        rd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(rsp_valid && !rsp_fwd && rsp_data == (MEM_KEY ^ 32'h500), "R8 memory value returned",
            rsp_data, MEM_KEY ^ 32'h500);
        strict_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_fwd();
        t_bypass();
        t_strict();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule